// File: doc/BRIEF.md
# LIN Command and Status Register Block

This block is the software-facing command and status logic of a LIN bus peripheral. A CPU writes and reads it over a simple byte-wide register bus with an indirect address. On the other side, a LIN protocol engine drives single-cycle event inputs into it: break seen, frame complete, wake-up received, wake-up sent, transmission complete, data acknowledge consumed, and error codes. The block turns command writes into level outputs and one-cycle pulses for that engine. It clears the handshake bits itself when the engine reports completion, and it keeps sticky status and error flags that software clears by writing one-bits into the command byte.

The command byte combines three kinds of bits. Some are plain stored bits: bus sleep and transmit/receive selection. Some are requests that hardware clears: start, wake-up and data acknowledge. The rest are write-only actions that always read back as zero: the processing stop, the interrupt clear and the error clear. A mode input selects master or slave operation. Commands that belong only to the other mode are dropped.

Top module: `lin_cmd_regs`

## Requirements
- R1: After reset every output is 0, and the command (address 0x08), status (0x09) and error (0x0A) registers all read 0x00.
- R2: Reads return data one cycle after the read strobe. The command byte reads back sleep in bit 6, tx/rx select in bit 5, data acknowledge in bit 4, wake request in bit 1 and start request in bit 0. Bits 7, 3 and 2 always read 0.
- R3: In master mode, writing bit 0 as 1 sets the start request and raises `start_pulse` for exactly the cycle after the write. The request stays set until the engine reports transmission done or a nonzero error code. In slave mode, or when bit 0 is written as 0, the write has no effect on the request.
- R4: Writing bit 1 as 1 sets the wake request in either mode and raises `wake_pulse` for exactly the cycle after the write. The request stays set until the engine reports that the wake-up was sent. Writing bit 1 as 0 has no effect.
- R5: In slave mode, writing bit 4 as 1 sets `dtack_flag` until the engine reports it consumed. In master mode the write has no effect.
- R6: In slave mode, writing bit 7 as 1 raises `proc_blocked` until the engine reports a break. While the block is blocked, frame-done events are discarded. In master mode bit 7 has no effect.
- R7: Status bit 0 (done) sets on an accepted frame-done. Bit 1 (wake) sets on a received wake-up while sleep is 1. Bit 2 (error) sets, and the error register ORs in the code, on a nonzero 4-bit error code. Bit 3 (interrupt, driven on `irq`) sets on any of these.
- R8: Writing bit 3 as 1 clears status bits 3, 1 and 0. Writing bit 2 as 1 clears status bit 2 and the error register. An event arriving in the same cycle as its clear leaves its flag set.
- R9: `sleep_flag` and `txrx_sel` follow bits 6 and 5 of every command write.
- R10: Writes to any address other than 0x08 change nothing. Reads of addresses other than 0x08, 0x09 and 0x0A return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Indirect register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| mode_master | input | 1 | 1 = master, 0 = slave |
| eng_break | input | 1 | Engine saw a break |
| eng_frame_done | input | 1 | Engine finished a valid frame |
| eng_wake_rx | input | 1 | Engine received a wake-up pulse |
| eng_wake_sent | input | 1 | Engine finished sending a wake-up |
| eng_tx_done | input | 1 | Engine finished a master transmission |
| eng_dtack_done | input | 1 | Engine consumed the data acknowledge |
| eng_err_bits | input | 4 | Error code, nonzero for one cycle on error |
| start_pulse | output | 1 | One-cycle transmission start |
| wake_pulse | output | 1 | One-cycle wake-up send |
| dtack_flag | output | 1 | Pending data acknowledge |
| txrx_sel | output | 1 | 1 = transmit frame, 0 = receive frame |
| sleep_flag | output | 1 | Bus sleep indication |
| proc_blocked | output | 1 | Frame processing stopped until break |
| irq | output | 1 | Interrupt flag |

## Verification
On every cycle, the assertions check that both request pulses last a single cycle and trace back to a matching write. They also check that a start pulse never follows a slave-mode write, that the block becomes blocked only after a slave-mode write, and that the interrupt falls only after a clear write. Only the directed scenarios can show the rest. That covers the read-back layout of the command byte and the discarding of frames while blocked. It also covers the sleep gating of wake-up status, the OR accumulation of error codes, the same-cycle race between an event and its clear, and the address decode.

// File: rtl/lin_cmd_pkg.sv
package lin_cmd_pkg;
  // Command byte layout, most significant bit first.
  typedef struct packed {
    logic stop;
    logic sleep;
    logic txrx;
    logic dtack;
    logic rst_int;
    logic rst_err;
    logic wupreq;
    logic streq;
  } ctrl_byte_t;

  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_WAKE = 1;
  localparam int unsigned ST_ERR  = 2;
  localparam int unsigned ST_INT  = 3;
endpackage

// File: rtl/lin_ctrl_bits.sv
module lin_ctrl_bits
  import lin_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  ctrl_byte_t wbyte,
  input  logic       mode_master,
  input  logic       eng_break,
  input  logic       eng_wake_sent,
  input  logic       eng_tx_done,
  input  logic       eng_err_any,
  input  logic       eng_dtack_done,
  output logic [7:0] ctrl_rd,
  output logic       start_pulse,
  output logic       wake_pulse,
  output logic       dtack_flag,
  output logic       txrx_sel,
  output logic       sleep_flag,
  output logic       proc_blocked
);
  logic streq_q, streq_n, wup_q, wup_n, dtack_q, dtack_n;
  logic blk_q, blk_n, sleep_q, sleep_n, txrx_q, txrx_n;
  logic stp_q, stp_n, wkp_q, wkp_n;

  always_comb begin
    streq_n = streq_q;
    wup_n   = wup_q;
    dtack_n = dtack_q;
    blk_n   = blk_q;
    sleep_n = sleep_q;
    txrx_n  = txrx_q;
    if (eng_tx_done || eng_err_any) streq_n = 1'b0;
    if (eng_wake_sent)              wup_n   = 1'b0;
    if (eng_dtack_done)             dtack_n = 1'b0;
    if (eng_break)                  blk_n   = 1'b0;
    stp_n = ctrl_wr && wbyte.streq && mode_master;
    wkp_n = ctrl_wr && wbyte.wupreq;
    if (stp_n) streq_n = 1'b1;
    if (wkp_n) wup_n   = 1'b1;
    if (ctrl_wr) begin
      sleep_n = wbyte.sleep;
      txrx_n  = wbyte.txrx;
      if (wbyte.dtack && !mode_master) dtack_n = 1'b1;
      if (wbyte.stop && !mode_master)  blk_n   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streq_q <= 1'b0;
      wup_q   <= 1'b0;
      dtack_q <= 1'b0;
      blk_q   <= 1'b0;
      sleep_q <= 1'b0;
      txrx_q  <= 1'b0;
      stp_q   <= 1'b0;
      wkp_q   <= 1'b0;
    end else begin
      streq_q <= streq_n;
      wup_q   <= wup_n;
      dtack_q <= dtack_n;
      blk_q   <= blk_n;
      sleep_q <= sleep_n;
      txrx_q  <= txrx_n;
      stp_q   <= stp_n;
      wkp_q   <= wkp_n;
    end
  end

  assign ctrl_rd      = {1'b0, sleep_q, txrx_q, dtack_q, 2'b00, wup_q, streq_q};
  assign start_pulse  = stp_q;
  assign wake_pulse   = wkp_q;
  assign dtack_flag   = dtack_q;
  assign txrx_sel     = txrx_q;
  assign sleep_flag   = sleep_q;
  assign proc_blocked = blk_q;
endmodule

// File: rtl/lin_status_flags.sv
module lin_status_flags
  import lin_cmd_pkg::*;
#(
  parameter int unsigned ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_int,
  input  logic             clr_err,
  input  logic             done_evt,
  input  logic             wake_evt,
  input  logic [ERR_W-1:0] err_bits,
  output logic [7:0]       stat_rd,
  output logic [7:0]       err_rd,
  output logic             irq
);
  localparam int unsigned PAD_W = 8 - ERR_W;

  logic             done_q, done_n, wake_q, wake_n, errf_q, errf_n, int_q, int_n;
  logic [ERR_W-1:0] err_q, err_n;
  logic             err_evt;

  always_comb begin
    err_evt = |err_bits;
    done_n  = (done_q & ~clr_int) | done_evt;
    wake_n  = (wake_q & ~clr_int) | wake_evt;
    int_n   = (int_q  & ~clr_int) | done_evt | wake_evt | err_evt;
    errf_n  = (errf_q & ~clr_err) | err_evt;
    err_n   = (clr_err ? '0 : err_q) | err_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      wake_q <= 1'b0;
      errf_q <= 1'b0;
      int_q  <= 1'b0;
      err_q  <= '0;
    end else begin
      done_q <= done_n;
      wake_q <= wake_n;
      errf_q <= errf_n;
      int_q  <= int_n;
      err_q  <= err_n;
    end
  end

  always_comb begin
    stat_rd          = 8'h00;
    stat_rd[ST_DONE] = done_q;
    stat_rd[ST_WAKE] = wake_q;
    stat_rd[ST_ERR]  = errf_q;
    stat_rd[ST_INT]  = int_q;
  end

  assign err_rd = {{PAD_W{1'b0}}, err_q};
  assign irq    = int_q;
endmodule

// File: rtl/lin_cmd_regs.sv
module lin_cmd_regs
  import lin_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned ERR_W     = 4,
  parameter logic [7:0]  CTRL_ADDR = 8'h08,
  parameter logic [7:0]  STAT_ADDR = 8'h09,
  parameter logic [7:0]  ERR_ADDR  = 8'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              mode_master,
  input  logic              eng_break,
  input  logic              eng_frame_done,
  input  logic              eng_wake_rx,
  input  logic              eng_wake_sent,
  input  logic              eng_tx_done,
  input  logic              eng_dtack_done,
  input  logic [ERR_W-1:0]  eng_err_bits,
  output logic              start_pulse,
  output logic              wake_pulse,
  output logic              dtack_flag,
  output logic              txrx_sel,
  output logic              sleep_flag,
  output logic              proc_blocked,
  output logic              irq
);
  logic       rs_meta, rs_n;
  logic       ctrl_wr;
  ctrl_byte_t wbyte;
  logic [7:0] ctrl_rd, stat_rd, err_rd;
  logic [7:0] rdata_q, rdata_n;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign wbyte   = ctrl_byte_t'(bus_wdata);

  lin_ctrl_bits ctrl_i (
    .clk(clk), .rst_n(rs_n), .ctrl_wr(ctrl_wr), .wbyte(wbyte),
    .mode_master(mode_master), .eng_break(eng_break),
    .eng_wake_sent(eng_wake_sent), .eng_tx_done(eng_tx_done),
    .eng_err_any(|eng_err_bits), .eng_dtack_done(eng_dtack_done),
    .ctrl_rd(ctrl_rd), .start_pulse(start_pulse), .wake_pulse(wake_pulse),
    .dtack_flag(dtack_flag), .txrx_sel(txrx_sel), .sleep_flag(sleep_flag),
    .proc_blocked(proc_blocked)
  );

  lin_status_flags #(.ERR_W(ERR_W)) stat_i (
    .clk(clk), .rst_n(rs_n),
    .clr_int(ctrl_wr && wbyte.rst_int),
    .clr_err(ctrl_wr && wbyte.rst_err),
    .done_evt(eng_frame_done && !proc_blocked),
    .wake_evt(eng_wake_rx && sleep_flag),
    .err_bits(eng_err_bits),
    .stat_rd(stat_rd), .err_rd(err_rd), .irq(irq)
  );

  always_comb begin
    rdata_n = rdata_q;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(CTRL_ADDR))      rdata_n = ctrl_rd;
      else if (bus_addr == ADDR_W'(STAT_ADDR)) rdata_n = stat_rd;
      else if (bus_addr == ADDR_W'(ERR_ADDR))  rdata_n = err_rd;
      else                                     rdata_n = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) rdata_q <= 8'h00;
    else       rdata_q <= rdata_n;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/lin_cmd_checks.sv
module lin_cmd_checks #(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              mode_master,
  input logic              start_pulse,
  input logic              wake_pulse,
  input logic              proc_blocked,
  input logic              irq
);
  logic cw;
  assign cw = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  assert_start_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(cw && bus_wdata[0] && mode_master));
  assert_start_slave_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && !mode_master) |=> !start_pulse);
  assert_wake_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  assert_wake_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(cw && bus_wdata[1]));
  assert_block_slave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proc_blocked) |-> $past(cw && bus_wdata[7] && !mode_master));
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(cw && bus_wdata[3]));
endmodule

bind lin_cmd_regs lin_cmd_checks #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) chk_i (.*);

// File: tb/lin_cmd_regs_tb.sv
module lin_cmd_regs_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       mode_master = 1'b0;
  logic       eng_break = 1'b0, eng_frame_done = 1'b0, eng_wake_rx = 1'b0;
  logic       eng_wake_sent = 1'b0, eng_tx_done = 1'b0, eng_dtack_done = 1'b0;
  logic [3:0] eng_err_bits = '0;
  logic       start_pulse, wake_pulse, dtack_flag, txrx_sel, sleep_flag;
  logic       proc_blocked, irq;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_cmd_regs dut_i (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 outputs", {1'b0, start_pulse, wake_pulse, dtack_flag, txrx_sel,
          sleep_flag, proc_blocked, irq}, 8'h00);
    rd_chk("R1 ctrl", 8'h08, 8'h00);
    rd_chk("R1 stat", 8'h09, 8'h00);
    rd_chk("R1 err",  8'h0A, 8'h00);
  endtask

  task automatic t_readback();
    mode_master = 1'b0;
    wr(8'h08, 8'h60);
    check("R9 txrx", {7'd0, txrx_sel}, 8'h01);
    check("R9 sleep", {7'd0, sleep_flag}, 8'h01);
    rd_chk("R2 ctrl 0x60", 8'h08, 8'h60);
    mode_master = 1'b1;
    wr(8'h08, 8'h9C);
    rd_chk("R2 ctrl write-only bits read 0", 8'h08, 8'h00);
    check("R6 stop ignored master", {7'd0, proc_blocked}, 8'h00);
    check("R5 dtack ignored master", {7'd0, dtack_flag}, 8'h00);
  endtask

  task automatic t_streq();
    mode_master = 1'b1;
    wr(8'h08, 8'h01);
    check("R3 pulse high", {7'd0, start_pulse}, 8'h01);
    @(negedge clk);
    check("R3 pulse one cycle", {7'd0, start_pulse}, 8'h00);
    wr(8'h08, 8'h00);
    rd_chk("R3 held after zero write", 8'h08, 8'h01);
    pulse(eng_tx_done);
    rd_chk("R3 cleared by tx done", 8'h08, 8'h00);
    wr(8'h08, 8'h01);
    @(negedge clk); eng_err_bits = 4'h2;
    @(negedge clk); eng_err_bits = 4'h0;
    rd_chk("R3 cleared by error", 8'h08, 8'h00);
    wr(8'h08, 8'h0C);
    mode_master = 1'b0;
    wr(8'h08, 8'h01);
    check("R3 no pulse in slave", {7'd0, start_pulse}, 8'h00);
    rd_chk("R3 no request in slave", 8'h08, 8'h00);
  endtask

  task automatic t_wupreq();
    wr(8'h08, 8'h02);
    check("R4 pulse high", {7'd0, wake_pulse}, 8'h01);
    @(negedge clk);
    check("R4 pulse one cycle", {7'd0, wake_pulse}, 8'h00);
    rd_chk("R4 request held", 8'h08, 8'h02);
    pulse(eng_wake_sent);
    rd_chk("R4 cleared by sent", 8'h08, 8'h00);
  endtask

  task automatic t_dtack();
    mode_master = 1'b0;
    wr(8'h08, 8'h10);
    check("R5 dtack set", {7'd0, dtack_flag}, 8'h01);
    rd_chk("R5 dtack read", 8'h08, 8'h10);
    pulse(eng_dtack_done);
    check("R5 dtack cleared", {7'd0, dtack_flag}, 8'h00);
  endtask

  task automatic t_stop();
    mode_master = 1'b0;
    wr(8'h08, 8'h80);
    check("R6 blocked", {7'd0, proc_blocked}, 8'h01);
    rd_chk("R2 stop reads 0", 8'h08, 8'h00);
    pulse(eng_frame_done);
    rd_chk("R6 frame discarded", 8'h09, 8'h00);
    pulse(eng_break);
    check("R6 unblocked by break", {7'd0, proc_blocked}, 8'h00);
    pulse(eng_frame_done);
    rd_chk("R7 done and int", 8'h09, 8'h09);
    check("R7 irq", {7'd0, irq}, 8'h01);
    wr(8'h08, 8'h08);
    rd_chk("R8 rstint clears", 8'h09, 8'h00);
  endtask

  task automatic t_status();
    wr(8'h08, 8'h40);
    pulse(eng_wake_rx);
    rd_chk("R7 wake while sleeping", 8'h09, 8'h0A);
    wr(8'h08, 8'h48);
    rd_chk("R8 clear wake", 8'h09, 8'h00);
    wr(8'h08, 8'h00);
    pulse(eng_wake_rx);
    rd_chk("R7 wake ignored awake", 8'h09, 8'h00);
    @(negedge clk); eng_err_bits = 4'h5;
    @(negedge clk); eng_err_bits = 4'h2;
    @(negedge clk); eng_err_bits = 4'h0;
    rd_chk("R7 error status", 8'h09, 8'h0C);
    rd_chk("R7 error accumulate", 8'h0A, 8'h07);
  endtask

  task automatic t_clear();
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 8'h04; eng_err_bits = 4'h8;
    @(negedge clk);
    bus_wr = 1'b0; eng_err_bits = 4'h0;
    rd_chk("R8 error event wins", 8'h0A, 8'h08);
    wr(8'h08, 8'h0C);
    rd_chk("R8 both cleared stat", 8'h09, 8'h00);
    rd_chk("R8 error reg cleared", 8'h0A, 8'h00);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 8'h08; eng_frame_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_frame_done = 1'b0;
    rd_chk("R8 done event wins", 8'h09, 8'h09);
    wr(8'h08, 8'h08);
  endtask

  task automatic t_addr();
    wr(8'h07, 8'h60);
    rd_chk("R10 other write ignored", 8'h08, 8'h00);
    check("R10 sleep untouched", {7'd0, sleep_flag}, 8'h00);
    rd_chk("R10 unmapped read", 8'h0B, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_streq();
    t_wupreq();
    t_dtack();
    t_stop();
    t_status();
    t_clear();
    t_addr();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule